// File: doc/BRIEF.md
# Outbound Retry Limit Counter

This block watches the master side of a PCI bridge and counts how often a target answers the current outbound request with a retry. A 3-bit limit code sets how many retries are tolerated. When that number is reached, the block raises a one-cycle abort pulse, and the request queue can then give up on the failing request. The no-limit code turns the abort off.

The limit code is logarithmic. Code zero means no limit. Each other code selects eight times a power of two: the limit doubles with each code step, from 8 up to 512. The count starts again from zero when a new outbound request begins, when a data phase completes, and after an abort. The current count is always visible on an output.

Top module: `retry_limit_ctr`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `retry_count_o` is 0 and `abort_o` is 0.
- R2: A clock edge that sees `retry_i` high, with `req_start_i` and `data_xfer_i` both low and no abort due, raises `retry_count_o` by exactly one for the following cycle.
- R3: A clock edge that sees `req_start_i` high sets `retry_count_o` to 0 and keeps `abort_o` low for the next cycle. A retry on that same edge is not counted and cannot cause an abort.
- R4: A clock edge that sees `data_xfer_i` high sets `retry_count_o` to 0 and keeps `abort_o` low for the next cycle. A retry on that same edge is not counted and cannot cause an abort.
- R5: For `limit_code_i` = k with 1 ≤ k ≤ 7, the limit is 8·2^(k−1), which gives 8, 16, 32, 64, 128, 256 or 512. The retry that brings the count to the limit makes `abort_o` high in the following cycle. In that same cycle `retry_count_o` reads 0.
- R6: With `limit_code_i` = 000, `abort_o` never rises. The count stops at its largest value, 1023, and does not wrap.
- R7: The limit code is read on every counted retry. If the count plus one is equal to or greater than the limit the code selects now, an abort is issued. This also covers a count that already passed a smaller limit selected later.
- R8: `abort_o` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start_i | input | 1 | A new outbound request starts this cycle |
| retry_i | input | 1 | The target answered with a retry this cycle |
| data_xfer_i | input | 1 | A data phase completed this cycle |
| limit_code_i | input | 3 | Retry limit code: 000 means no limit, k means 8·2^(k−1) |
| abort_o | output | 1 | One-cycle pulse: abort the pending outbound request |
| retry_count_o | output | 10 | Retries counted for the current request |

## Verification
A retry strobe can arrive on the same edge as a request start or a data-phase completion. The bench provokes this in two places: at an arbitrary count, and on the exact retry that would otherwise reach the limit. It judges the result at the ports. In the cycle after such an edge, the count must read zero and the abort must stay low, where a lone retry would have aborted. A second collision is a change of limit code in the middle of a request. The bench moves to a smaller limit that the count has already passed, then checks that the next retry aborts at once.

// File: rtl/rlc_pkg.sv
// Package: shared sizing for the outbound retry limit counter.
// Assumes the limit code is logarithmic: code k>0 selects 2^(BASE_SHIFT+k-1).
package rlc_pkg;
    localparam int unsigned CODE_W     = 3;   // width of the limit code
    localparam int unsigned BASE_SHIFT = 3;   // smallest limit is 2^BASE_SHIFT
    localparam int unsigned CNT_W      = 10;  // counter width, reaches 512
    localparam int unsigned MAX_LOG2   = BASE_SHIFT + (1 << CODE_W) - 2;

    typedef logic [CODE_W-1:0] limit_code_t;
endpackage

// File: rtl/rlc_limit_decode.sv
// Module: turns the logarithmic limit code into a terminal count.
// Assumes code 0 is the no-limit code and that CNT_W > MAX_LOG2, so the
// largest limit fits in the counter.
module rlc_limit_decode
    import rlc_pkg::*;
#(
    parameter int unsigned P_CODE_W  = CODE_W,
    parameter int unsigned P_BASE_SH = BASE_SHIFT,
    parameter int unsigned P_CNT_W   = CNT_W
) (
    input  logic [P_CODE_W-1:0] code_i,
    output logic [P_CNT_W-1:0]  limit_o,
    output logic                unlimited_o
);
    localparam int unsigned NUM_CODES = 1 << P_CODE_W;

    // Purpose: pick the one-hot limit that belongs to the code.
    always_comb begin
        limit_o     = '0;
        unlimited_o = (code_i == '0);
        for (int k = 1; k < NUM_CODES; k++) begin
            if (code_i == P_CODE_W'(k)) begin
                limit_o = P_CNT_W'(1) << (P_BASE_SH + k - 1);
            end
        end
    end
endmodule

// File: rtl/rlc_limit_cmp.sv
// Module: decides whether the retry seen this cycle reaches the limit.
// Assumes a clear (request start or data phase) has priority over a retry.
// Uses >= so that a smaller limit set in the middle of a request takes
// effect on the next retry.
module rlc_limit_cmp
    import rlc_pkg::*;
#(
    parameter int unsigned P_CNT_W = CNT_W
) (
    input  logic [P_CNT_W-1:0] count_i,
    input  logic [P_CNT_W-1:0] limit_i,
    input  logic               unlimited_i,
    input  logic               retry_i,
    input  logic               clear_i,
    output logic               hit_o
);
    logic [P_CNT_W:0] next_cnt;

    // Purpose: compare the count after this retry with the limit.
    always_comb begin
        next_cnt = {1'b0, count_i} + {{P_CNT_W{1'b0}}, 1'b1};
        hit_o    = retry_i && !clear_i && !unlimited_i &&
                   (next_cnt >= {1'b0, limit_i});
    end
endmodule

// File: rtl/rlc_retry_counter.sv
// Module: the retry count register. It clears on a request start, a data
// phase or an abort, and otherwise steps up by one on each retry.
// Assumes clear_i already contains every reason to clear. SATURATE picks
// between a counter that stops at its top value and one that wraps.
module rlc_retry_counter
    import rlc_pkg::*;
#(
    parameter int unsigned P_CNT_W  = CNT_W,
    parameter bit          SATURATE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               inc_i,
    output logic [P_CNT_W-1:0] count_o
);
    logic [P_CNT_W-1:0] cnt_q;
    logic [P_CNT_W-1:0] cnt_inc;

    generate
        if (SATURATE) begin : g_sat
            // Purpose: add one, but stop at the all-ones value.
            always_comb cnt_inc = (&cnt_q) ? cnt_q : cnt_q + P_CNT_W'(1);
        end else begin : g_wrap
            // Purpose: add one and let the value wrap past all ones.
            always_comb cnt_inc = cnt_q + P_CNT_W'(1);
        end
    endgenerate

    // Purpose: count register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_inc;
        end
    end

    assign count_o = cnt_q;

    // The count either holds, drops to zero, steps up by one or stays at its top value.
    AST_STEP_OR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + P_CNT_W'(1))); // R2
endmodule

// File: rtl/retry_limit_ctr.sv
// Module: top of the outbound retry limit counter. It counts the retries
// that a target returns for the pending outbound request and pulses
// abort_o for one cycle when the count reaches the limit that the code
// selects.
// Assumes all strobes are synchronous to clk and that only one outbound
// request is pending at a time.
module retry_limit_ctr
    import rlc_pkg::*;
#(
    parameter int unsigned P_CODE_W  = CODE_W,
    parameter int unsigned P_BASE_SH = BASE_SHIFT,
    parameter int unsigned P_CNT_W   = CNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_start_i,
    input  logic                retry_i,
    input  logic                data_xfer_i,
    input  logic [P_CODE_W-1:0] limit_code_i,
    output logic                abort_o,
    output logic [P_CNT_W-1:0]  retry_count_o
);
    logic               clr_req;
    logic [P_CNT_W-1:0] limit_val;
    logic               no_limit;
    logic               limit_hit;
    logic [P_CNT_W-1:0] count_val;
    logic               abort_q;

    // Purpose: merge the reasons that end the current retry sequence.
    always_comb clr_req = req_start_i || data_xfer_i;

    rlc_limit_decode #(
        .P_CODE_W (P_CODE_W),
        .P_BASE_SH(P_BASE_SH),
        .P_CNT_W  (P_CNT_W)
    ) u_decode (
        .code_i     (limit_code_i),
        .limit_o    (limit_val),
        .unlimited_o(no_limit)
    );

    rlc_limit_cmp #(
        .P_CNT_W(P_CNT_W)
    ) u_cmp (
        .count_i    (count_val),
        .limit_i    (limit_val),
        .unlimited_i(no_limit),
        .retry_i    (retry_i),
        .clear_i    (clr_req),
        .hit_o      (limit_hit)
    );

    rlc_retry_counter #(
        .P_CNT_W (P_CNT_W),
        .SATURATE(1'b1)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(clr_req || limit_hit),
        .inc_i  (retry_i),
        .count_o(count_val)
    );

    // Purpose: register the abort pulse, one cycle after the terminal retry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_q <= 1'b0;
        end else begin
            abort_q <= limit_hit;
        end
    end

    assign abort_o       = abort_q;
    assign retry_count_o = count_val;

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        req_start_i |=> (retry_count_o == '0 && !abort_o)); // R3
    AST_XFER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        data_xfer_i |=> (retry_count_o == '0 && !abort_o)); // R4
    AST_ABORT_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (retry_count_o == '0)); // R5
    AST_UNLIMITED_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> ($past(limit_code_i) != '0 && $past(retry_i))); // R6
    AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o); // R8
endmodule

// File: tb/retry_limit_ctr_tb.sv
// Bench: sweeps every limit code, the collision cases and a limit change
// mid-request. It compares the ports each cycle against a model built
// from the requirements.
module retry_limit_ctr_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_start, retry, data_xfer;
    logic [2:0] code;
    logic       abort;
    logic [9:0] count;

    int compared   = 0;
    int mismatched = 0;
    int exp_cnt    = 0;
    bit exp_abort  = 1'b0;
    bit done       = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    retry_limit_ctr u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_start_i  (req_start),
        .retry_i      (retry),
        .data_xfer_i  (data_xfer),
        .limit_code_i (code),
        .abort_o      (abort),
        .retry_count_o(count)
    );

    function automatic int limit_of(input logic [2:0] c);
        return (c == 3'd0) ? 0 : (8 << (c - 1));
    endfunction

    task automatic check(input string tag);
        compared++;
        if (count !== 10'(exp_cnt) || abort !== exp_abort) begin
            mismatched++;
            $display("FAIL %s: count=%0d abort=%0b expected count=%0d abort=%0b",
                     tag, count, abort, exp_cnt, exp_abort);
        end
    endtask

    // Drive one cycle, update the model, then check 1 ns after the edge.
    task automatic cyc(input bit s, input bit r, input bit x,
                       input logic [2:0] c, input string tag);
        @(negedge clk);
        req_start = s; retry = r; data_xfer = x; code = c;
        @(posedge clk);
        if (s || x) begin
            exp_cnt = 0; exp_abort = 1'b0;
        end else if (r) begin
            if (c != 3'd0 && exp_cnt + 1 >= limit_of(c)) begin
                exp_cnt = 0; exp_abort = 1'b1;
            end else begin
                exp_abort = 1'b0;
                exp_cnt = (exp_cnt == 1023) ? 1023 : exp_cnt + 1;
            end
        end else begin
            exp_abort = 1'b0;
        end
        #1;
        check(tag);
        req_start = 1'b0; retry = 1'b0; data_xfer = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_start = 1'b0; retry = 1'b0; data_xfer = 1'b0; code = 3'd0;
        repeat (3) @(posedge clk);
        #1 check("R1 in reset");
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1 check("R1 after reset");

        // R5 R2: every limited code, counted up to the abort.
        for (int c = 1; c < 8; c++) begin
            cyc(1, 0, 0, 3'(c), "R3 start");
            for (int i = 0; i < limit_of(3'(c)); i++)
                cyc(0, 1, 0, 3'(c), "R5 R2 sweep");
            if (!exp_abort) begin
                mismatched++;
                $display("FAIL R5 model: actual=no abort expected=abort");
            end
            cyc(0, 0, 0, 3'(c), "R8 idle after abort");
        end

        // R6: unlimited code, counting past the top value.
        cyc(1, 0, 0, 3'd0, "R3 start");
        for (int i = 0; i < 1030; i++) cyc(0, 1, 0, 3'd0, "R6 no limit");

        // R3 R4: a retry colliding with a clear, at an arbitrary count and at the terminal retry.
        cyc(1, 0, 0, 3'd1, "R3 start");
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, 3'd1, "R2 step");
        cyc(0, 1, 1, 3'd1, "R4 xfer beats retry");
        for (int i = 0; i < 7; i++) cyc(0, 1, 0, 3'd1, "R2 step");
        cyc(1, 1, 0, 3'd1, "R3 start beats terminal retry");
        for (int i = 0; i < 7; i++) cyc(0, 1, 0, 3'd1, "R2 step");
        cyc(0, 1, 1, 3'd1, "R4 xfer beats terminal retry");
        cyc(0, 0, 0, 3'd1, "R4 idle");

        // R7: move to a smaller limit that the count has already passed.
        cyc(1, 0, 0, 3'd3, "R3 start");
        for (int i = 0; i < 20; i++) cyc(0, 1, 0, 3'd3, "R2 step");
        cyc(0, 0, 0, 3'd1, "R7 idle holds");
        cyc(0, 1, 0, 3'd1, "R7 abort on lowered limit");
        cyc(0, 0, 0, 3'd1, "R8 single pulse");

        // R1: reset in the middle of counting.
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, 3'd2, "R2 step");
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1;
        exp_cnt = 0; exp_abort = 1'b0;
        check("R1 mid-run reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule